// File: doc/BRIEF.md
# Dual-Edge Sample Stream Reassembler

This block sits behind a two-channel converter that is run with both channels sampling one input on opposite clock edges. The converter delivers its results on parallel byte lanes. The block turns those lanes into a single stream of samples in time order. Each output beat carries four 10-bit samples, with the earliest sample in the lowest slot.

Two lane layouts are supported. In demux layout, each input beat carries four lanes: I, Q, delayed I and delayed Q. In non-demux layout, each input beat carries one edge's worth of data, which is the I and Q lanes only. The block pairs two successive beats of that kind into one output word.

When the dual-edge enable bit is clear, the two channels are treated as separate streams. In that case the I pair and the Q pair are packed side by side and not interleaved. A two-entry buffer absorbs back-pressure from the output. The input cannot be stalled, so a word that finds the buffer full raises a sticky overflow flag.

Top module: `des_reassembler`

## Requirements
- R1: After reset, `out_valid`, `cfg_err` and `ovf_err` are 0.
- R2: With dual-edge on (`de_ctrl[2]`=1) and `demux`=1, each input beat yields one word. Slot 0 (bits 9:0) holds delayed Q, slot 1 holds delayed I, slot 2 holds Q and slot 3 (bits 39:30) holds I.
- R3: With dual-edge on and `demux`=0, two successive input beats form one word. Slot 0 is the first beat's Q, slot 1 the first beat's I, slot 2 the second beat's Q and slot 3 the second beat's I.
- R4: With dual-edge off and `demux`=1, the word is: slot 0 delayed I, slot 1 I, slot 2 delayed Q, slot 3 Q.
- R5: With dual-edge off and `demux`=0, a pair of beats gives: slot 0 first I, slot 1 second I, slot 2 first Q, slot 3 second Q.
- R6: `out_src` carries `de_ctrl[1:0]` (bit 1 = Q input selected, bit 0 = both inputs driven), as sampled on the beat that completed the word.
- R7: `cfg_err` is high one cycle after `de_ctrl[2]`=1 while `i_active` or `q_active` is 0. It is low one cycle after that condition is absent.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output word and `out_valid` hold unchanged on the next cycle.
- R9: The output buffer holds two words. A completed word that arrives while two are held and none leaves is dropped, and it sets `ovf_err`. `ovf_err` then stays 1 until reset.
- R10: A word appears on the output in the cycle after its last input beat, provided the buffer was empty. Words leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_ctrl | input | 3 | [2] dual-edge enable, [1] Q input select, [0] both inputs driven |
| demux | input | 1 | 1 = four lanes per beat, 0 = two lanes per beat |
| i_active | input | 1 | I lane group powered |
| q_active | input | 1 | Q lane group powered |
| in_valid | input | 1 | Input lanes carry a beat |
| lane_i | input | 10 | I lane |
| lane_q | input | 10 | Q lane |
| lane_id | input | 10 | Delayed I lane (demux only) |
| lane_qd | input | 10 | Delayed Q lane (demux only) |
| out_data | output | 40 | Four samples, earliest in bits 9:0 |
| out_src | output | 2 | Input-select tag of the word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| cfg_err | output | 1 | Dual-edge enabled with a lane group inactive |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The lanes are driven with values that differ on every lane and every beat. Any swap of slots, lanes or beats therefore shows up as a wrong word. All four combinations of layout and dual-edge setting are run, so the interleaved order can be told apart from the side-by-side order. Non-demux beats are sent with idle gaps between them, which checks that a pair joins across gaps. Back-pressure runs then hold `out_ready` low long enough to fill the buffer and overflow it. A final pattern sets each lane group inactive in turn.

// File: rtl/des_reassembler.sv
module des_reassembler #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    de_ctrl,
  input  logic          demux,
  input  logic          i_active,
  input  logic          q_active,
  input  logic          in_valid,
  input  logic [SW-1:0] lane_i,
  input  logic [SW-1:0] lane_q,
  input  logic [SW-1:0] lane_id,
  input  logic [SW-1:0] lane_qd,
  output logic [4*SW-1:0] out_data,
  output logic [1:0]    out_src,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          cfg_err,
  output logic          ovf_err
);
  localparam int WW = 4 * SW;

  logic          half;
  logic [SW-1:0] hold_i, hold_q;
  logic [WW-1:0] word;
  logic          word_rdy;
  logic [WW-1:0] mem_d [2];
  logic [1:0]    mem_s [2];
  logic          wr_ptr, rd_ptr;
  logic [1:0]    count;
  logic          pop, full, accept;

  wire de_on = de_ctrl[2];

  always_comb begin
    if (demux)
      word = de_on ? {lane_i, lane_q, lane_id, lane_qd}
                   : {lane_q, lane_qd, lane_i, lane_id};
    else
      word = de_on ? {lane_i, lane_q, hold_i, hold_q}
                   : {lane_q, hold_q, lane_i, hold_i};
  end

  assign word_rdy  = in_valid & (demux | half);
  assign out_valid = count != 2'd0;
  assign pop       = out_valid & out_ready;
  assign full      = count == 2'd2;
  assign accept    = word_rdy & (~full | pop);
  assign out_data  = mem_d[rd_ptr];
  assign out_src   = mem_s[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
    end else if (demux) begin
      half <= 1'b0;
    end else if (in_valid) begin
      half <= ~half;
      if (!half) begin
        hold_i <= lane_i;
        hold_q <= lane_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= 1'b0;
      rd_ptr  <= 1'b0;
      count   <= 2'd0;
      ovf_err <= 1'b0;
      cfg_err <= 1'b0;
      mem_d[0] <= '0;
      mem_d[1] <= '0;
      mem_s[0] <= '0;
      mem_s[1] <= '0;
    end else begin
      cfg_err <= de_on & ~(i_active & q_active);
      if (accept) begin
        mem_d[wr_ptr] <= word;
        mem_s[wr_ptr] <= de_ctrl[1:0];
        wr_ptr <= ~wr_ptr;
      end
      if (pop) rd_ptr <= ~rd_ptr;
      count <= count + {1'b0, accept} - {1'b0, pop};
      if (word_rdy & ~accept) ovf_err <= 1'b1;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r7_cfg_set: assert property (@(posedge clk) disable iff (!rst_n)
    (de_ctrl[2] && !(i_active && q_active)) |=> cfg_err);

  a_r7_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(de_ctrl[2] && !(i_active && q_active)) |=> !cfg_err);

  a_r10_word_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (word_rdy && !out_valid) |=> out_valid);

  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !word_rdy) |=> !out_valid);
endmodule

// File: tb/des_reassembler_bench.sv
module des_reassembler_bench;
  localparam int SW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] de_ctrl = 3'b100;
  logic demux = 1'b1, i_active = 1'b1, q_active = 1'b1, in_valid = 1'b0, out_ready = 1'b1;
  logic [SW-1:0] lane_i = '0, lane_q = '0, lane_id = '0, lane_qd = '0;
  logic [4*SW-1:0] out_data;
  logic [1:0] out_src;
  logic out_valid, cfg_err, ovf_err;

  int checks = 0, fails = 0, cyc = 0;
  logic [4*SW-1:0] mq[$];
  logic [1:0] sq[$];
  string tq[$];
  logic m_half = 0, m_ovf = 0, m_cfg = 0;
  logic [SW-1:0] p_i, p_q;

  des_reassembler #(.SW(SW)) u_des_reassembler (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); sq.delete(); tq.delete();
      m_half = 0; m_ovf = 0; m_cfg = 0;
    end else begin
      logic [4*SW-1:0] w;
      bit have, pop;
      string tg;
      have = 0;
      pop = (mq.size() > 0) && out_ready;
      m_cfg = de_ctrl[2] && !(i_active && q_active);
      if (in_valid) begin
        if (demux) begin
          have = 1;
          if (de_ctrl[2]) begin w = {lane_i, lane_q, lane_id, lane_qd}; tg = "R2"; end
          else            begin w = {lane_q, lane_qd, lane_i, lane_id}; tg = "R4"; end
        end else if (!m_half) begin
          p_i = lane_i; p_q = lane_q; m_half = 1;
        end else begin
          have = 1; m_half = 0;
          if (de_ctrl[2]) begin w = {lane_i, lane_q, p_i, p_q}; tg = "R3"; end
          else            begin w = {lane_q, p_q, lane_i, p_i}; tg = "R5"; end
        end
      end
      if (demux) m_half = 0;
      if (pop) begin void'(mq.pop_front()); void'(sq.pop_front()); void'(tq.pop_front()); end
      if (have) begin
        if (mq.size() < 2) begin mq.push_back(w); sq.push_back(de_ctrl[1:0]); tq.push_back(tg); end
        else m_ovf = 1;
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(out_valid == (mq.size() > 0), "R10 valid", 64'(out_valid), 64'(mq.size() > 0));
      if (out_valid && mq.size() > 0) begin
        chk(out_data == mq[0], tq[0], 64'(out_data), 64'(mq[0]));
        chk(out_src == sq[0], "R6", 64'(out_src), 64'(sq[0]));
      end
      chk(ovf_err == m_ovf, "R9", 64'(ovf_err), 64'(m_ovf));
      chk(cfg_err == m_cfg, "R7", 64'(cfg_err), 64'(m_cfg));
    end
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  int v = 1;
  task automatic beat();
    in_valid = 1;
    lane_i = SW'(v * 7 + 1); lane_q = SW'(v * 7 + 2);
    lane_id = SW'(v * 7 + 3); lane_qd = SW'(v * 7 + 4);
    v++;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !cfg_err && !ovf_err, "R1", 64'({out_valid, cfg_err, ovf_err}), 64'(0));
    // R2 interleaved, four lanes
    de_ctrl = 3'b110;
    repeat (4) beat();
    beat(); idle(2); beat();
    // R3 interleaved, two lanes, pairs with gaps
    demux = 0; de_ctrl = 3'b101;
    repeat (4) beat();
    beat(); idle(3); beat(); idle(1);
    // R4 / R5 separate streams
    demux = 1; de_ctrl = 3'b011;
    repeat (3) beat();
    demux = 0; de_ctrl = 3'b000;
    repeat (4) beat(); idle(2);
    // R8 / R9 back-pressure and overflow
    demux = 1; de_ctrl = 3'b100; out_ready = 0;
    beat(); beat(); idle(3);
    chk(out_valid && !ovf_err, "R9 two held", 64'({out_valid, ovf_err}), 64'(2));
    beat(); idle(1);
    chk(ovf_err == 1, "R9 overflow", 64'(ovf_err), 64'(1));
    out_ready = 1; idle(4);
    chk(ovf_err == 1, "R9 sticky", 64'(ovf_err), 64'(1));
    out_ready = 0; demux = 0;
    beat(); beat(); idle(1);
    out_ready = 1; idle(3);
    // R7 lane groups inactive
    i_active = 0; idle(2);
    chk(cfg_err == 1, "R7 i off", 64'(cfg_err), 64'(1));
    i_active = 1; q_active = 0; idle(2);
    chk(cfg_err == 1, "R7 q off", 64'(cfg_err), 64'(1));
    de_ctrl = 3'b000; idle(2);
    chk(cfg_err == 0, "R7 disabled", 64'(cfg_err), 64'(0));
    q_active = 1;
    rst_n = 0; idle(2); rst_n = 1; @(negedge clk);
    chk(!ovf_err && !out_valid, "R1 R9 cleared", 64'({ovf_err, out_valid}), 64'(0));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule